// File: doc/BRIEF.md
# Two-Bank Keyed Numerically Controlled Oscillator

This block is a numerically controlled oscillator that produces a 12-bit carrier phase word for frequency-shift and phase-shift keying. A 28-bit phase accumulator adds one of two stored tuning words on every clock. A one-bit frequency select input chooses which word is added, so a serial bit stream on that input gives binary FSK. A two-bit phase select input picks one of four stored phase offsets, and that offset is added to the top bits of the accumulator. Keeping the offset out of the increment leaves the carrier frequency unchanged. Two preloaded offsets give BPSK, and four give QPSK. The output phase word is meant to address a sine lookup that sits outside this block.

Software loads the tuning words and offsets through a write port made of an address, a data word and a write enable. This is done before transmission starts. From then on, only the select inputs change, one symbol at a time. A synchronous reset clears the accumulator and all stored words. Several instances that share one clock and one reset therefore start from the same phase and keep a fixed phase relationship.

Top module: `nco_keyer`

## Requirements
- R1: While reset is high, and on the first rising edge after it, the accumulator, both tuning words, all four offsets and `phase_out` are zero. With no writes afterwards, `phase_out` stays 0.
- R2: A write (`wr_en`=1 at a rising edge) decodes `wr_addr` as follows. Address 0 loads the space tuning word and address 1 loads the mark tuning word, each from all 28 bits of `wr_data`. Addresses 4 to 7 load phase offsets 0 to 3 from `wr_data[11:0]`. Addresses 2 and 3 change nothing.
- R3: On each rising edge outside reset, the accumulator becomes (accumulator + selected tuning word) mod 2^28. `phase_out` becomes bits [27:16] of that new value plus the selected offset, mod 4096. Low accumulator bits carry into the output even when the tuning word is not a multiple of 2^16.
- R4: When `fsel` is 1 at an edge, the mark tuning word is added at that edge. When it is 0, the space word is added. A change on `fsel` first matters at the next edge.
- R5: The selected phase offset never alters the accumulator. Changing `psel` shifts `phase_out` only by the difference between offsets and leaves the per-cycle increment unchanged.
- R6: With offsets 0 and 0x800 loaded and `psel` toggling, `phase_out` flips by exactly 180 degrees (0x800) relative to the unshifted phase.
- R7: With offsets 0x000, 0x400, 0xC00 and 0x800 loaded, each of the four `psel` codes (0 to 3) adds its own offset.
- R8: A synchronous reset in the middle of a run returns the accumulator to phase 0. Reloading the same words afterwards reproduces the same output sequence as the first run.
- R9: The accumulator wraps modulo 2^28 without saturating.
- R10: A write presented while reset is high is ignored.
- R11: A value written at one edge is first used by the accumulation at the next edge, and the edge of the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address (0/1 tuning words, 4-7 phase offsets) |
| wr_data | input | 28 | Write data |
| fsel | input | 1 | Frequency select: 1 mark, 0 space |
| psel | input | 2 | Phase offset select |
| phase_out | output | 12 | Truncated carrier phase plus offset |

## Verification
A single tuning word with no offset checks the plain accumulate-and-truncate path. A tuning word with nonzero low bits and a near-full-scale word check, respectively, the carry from discarded bits and the modulo wrap. An irregular `fsel` bit pattern shows that the mark and space words are switched cycle by cycle without a one-cycle slip. Alternating two offsets and then cycling four quadrature offsets separates the phase path from the frequency path, while writes to unused addresses and writes made during reset show that stored words are left alone. A mid-run reset followed by a replay must reproduce the first run's phase sequence, which is the property that keeps parallel instances coherent.

// File: rtl/nco_keyer.sv
module nco_keyer #(
  parameter int ACC_W = 28,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fsel,
  input  logic [1:0]       psel,
  output logic [OUT_W-1:0] phase_out
);
  localparam int TOP_LSB = ACC_W - OUT_W;

  logic [1:0][ACC_W-1:0] ftw;
  logic [3:0][OUT_W-1:0] poff;
  logic [ACC_W-1:0]      acc;
  logic [OUT_W-1:0]      phase_q;

  wire [ACC_W-1:0] step     = ftw[fsel];
  wire [ACC_W-1:0] acc_nxt  = acc + step;
  wire [OUT_W-1:0] poff_sel = poff[psel];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      ftw     <= '0;
      poff    <= '0;
      phase_q <= '0;
    end else begin
      acc     <= acc_nxt;
      phase_q <= acc_nxt[ACC_W-1:TOP_LSB] + poff_sel;
      if (wr_en) begin
        if (wr_addr[2])
          poff[wr_addr[1:0]] <= wr_data[OUT_W-1:0];
        else if (!wr_addr[1])
          ftw[wr_addr[0]] <= wr_data;
      end
    end
  end

  assign phase_out = phase_q;

  // R1: reset clears the phase state
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && acc == '0));

  // R10: writes during reset are dropped
  a_r10_reset_write: assert property (@(posedge clk)
    (rst && wr_en) |=> (ftw == '0 && poff == '0));

  // R2: unused addresses leave stored words alone
  a_r2_bad_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[2:1] == 2'b01) |=> ($stable(ftw) && $stable(poff)));

  // R5: the offset never moves the accumulator
  a_r5_offset_no_freq: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> $stable(acc));

  // R3: output is truncated accumulator plus the offset chosen one edge earlier
  a_r3_out_sum: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (phase_out == OUT_W'(acc[ACC_W-1:TOP_LSB] + $past(poff_sel))));
endmodule

// File: tb/nco_keyer_tb.sv
module nco_keyer_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [27:0] wr_data = 0;
  logic        fsel = 0;
  logic [1:0]  psel = 0;
  logic [11:0] phase_out;

  int checks = 0;
  int errors = 0;

  logic [27:0] m_acc;
  logic [27:0] m_ftw [2];
  logic [11:0] m_poff [4];
  logic [11:0] m_exp;
  logic [11:0] run1 [8];

  always #4 clk = ~clk;

  nco_keyer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsel(fsel), .psel(psel), .phase_out(phase_out)
  );

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: phase_out=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic f, input logic [1:0] p,
                      input logic w, input logic [2:0] a, input logic [27:0] d,
                      input string tag);
    @(negedge clk);
    rst = r; fsel = f; psel = p; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    if (r) begin
      m_acc = 0;
      m_exp = 0;
      for (int i = 0; i < 2; i++) m_ftw[i] = 0;
      for (int i = 0; i < 4; i++) m_poff[i] = 0;
    end else begin
      m_acc = m_acc + m_ftw[f];
      m_exp = m_acc[27:16] + m_poff[p];
      if (w) begin
        if (a[2]) m_poff[a[1:0]] = d[11:0];
        else if (!a[1]) m_ftw[a[0]] = d;
      end
    end
    check(tag, phase_out, m_exp);
  endtask

  task automatic tick(input logic f, input logic [1:0] p, input string tag);
    step(0, f, p, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [27:0] d, input string tag);
    step(0, 0, 0, 1, a, d, tag);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R1 reset");
    for (int i = 0; i < 4; i++) tick(i[0], i[1:0], "R1 idle after reset");
  endtask

  task automatic t_space;
    wr(0, 28'h0100000, "R11 write edge uses old word");
    for (int i = 0; i < 5; i++) tick(0, 0, "R3 space accumulate");
  endtask

  task automatic t_fsk;
    wr(1, 28'h0300000, "R2 mark write");
    tick(1, 0, "R4 mark");
    tick(0, 0, "R4 space");
    tick(1, 0, "R4 mark");
    tick(1, 0, "R4 mark");
    tick(0, 0, "R4 space");
    tick(1, 0, "R4 mark");
  endtask

  task automatic t_carry_wrap;
    wr(0, 28'h0012345, "R3 odd word write");
    for (int i = 0; i < 6; i++) tick(0, 0, "R3 low-bit carry");
    wr(1, 28'hFFF0000, "R9 big word write");
    for (int i = 0; i < 6; i++) tick(1, 0, "R9 wrap");
  endtask

  task automatic t_bpsk;
    wr(0, 28'h0100000, "R2 space reload");
    wr(4, 28'h0000000, "R2 offset0");
    wr(5, 28'hABCD800, "R2 offset1 low bits only");
    for (int i = 0; i < 6; i++) tick(0, i[0] ? 2'd1 : 2'd0, "R6 bpsk toggle");
    tick(0, 1, "R5 offset keeps increment");
    tick(0, 1, "R5 offset keeps increment");
  endtask

  task automatic t_qpsk;
    wr(4, 28'h000, "R7 q0");
    wr(5, 28'h400, "R7 q1");
    wr(6, 28'hC00, "R7 q2");
    wr(7, 28'h800, "R7 q3");
    tick(0, 0, "R7 psel0");
    tick(0, 1, "R7 psel1 +90");
    tick(0, 2, "R7 psel2 -90");
    tick(0, 3, "R7 psel3 180");
    tick(1, 2, "R7 mark with -90");
  endtask

  task automatic t_bad_addr;
    wr(2, 28'hFFFFFFF, "R2 addr2 ignored");
    wr(3, 28'h5555555, "R2 addr3 ignored");
    for (int i = 0; i < 4; i++) tick(i[0], i[1:0], "R2 stored words unchanged");
  endtask

  task automatic t_reset_write;
    step(1, 0, 0, 1, 0, 28'h0700000, "R10 write in reset");
    step(1, 0, 0, 1, 5, 28'h0000123, "R10 write in reset");
    for (int i = 0; i < 3; i++) tick(i[0], 1, "R10 nothing stored");
  endtask

  task automatic t_resync;
    wr(0, 28'h0234567, "R8 load");
    wr(1, 28'h0890000, "R8 load");
    for (int i = 0; i < 8; i++) begin
      tick(i[1] ^ i[0], 0, "R8 first run");
      run1[i] = phase_out;
    end
    step(1, 0, 0, 0, 0, 0, "R8 mid-run reset");
    wr(0, 28'h0234567, "R8 reload");
    wr(1, 28'h0890000, "R8 reload");
    for (int i = 0; i < 8; i++) begin
      tick(i[1] ^ i[0], 0, "R8 replay");
      check("R8 replay matches first run", phase_out, run1[i]);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: phase_out=%h expected=done", phase_out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_acc = 0;
    m_exp = 0;
    t_reset;
    t_space;
    t_fsk;
    t_carry_wrap;
    t_bpsk;
    t_qpsk;
    t_bad_addr;
    t_reset_write;
    t_resync;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule